// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block runs one access at a time from a processor core to external memory or peripherals. The core raises a one-cycle request with an address, a direction and write data. The controller latches them and drives the external address for one setup cycle. It then asserts a read or write strobe for a number of cycles set by the bank being addressed, and reports completion with a single-cycle done pulse. On reads, the core receives the data captured on the last strobe cycle.

The top address bits pick one of several banks, and each bank has a one-hot select output. Every bank has a 3-bit wait field on a configuration input. Besides these counted waits, an external device can stretch the access by holding the acknowledge input low. A bus-suspend input releases the external bus: the drive-enable output goes low one cycle later, and the pad ring turns that into high impedance on the address, data, select and strobe pins. While the bus is suspended, and for the one cycle after it is driven again, the access is frozen. It then resumes from where it stopped.

Top module: `xbus_waitstate_ctl`

## Requirements
- R1: After reset, core_done, ext_rd, ext_wr and every bit of ext_bsel are 0, and ext_oe is 1.
- R2: From the setup cycle through the last strobe cycle, ext_bsel has exactly bit b set, where b is the value of the top two bits of core_addr latched at the request. In idle and done cycles, ext_bsel is all zero.
- R3: With acknowledge high and no suspend, an access to bank b whose wait field cfg_wait[3b+2:3b] holds N strobes for N+1 cycles. core_done is high in the cycle after the (N+2)-th rising edge that follows the edge sampling core_req.
- R4: If acknowledge is low at the edge that ends the last counted strobe cycle, the strobe stays on and the access completes at the first later edge where acknowledge is high.
- R5: The acknowledge level during the counted wait cycles has no effect on when the access ends.
- R6: ext_rd strobes when core_we was 0 at the request, and ext_wr strobes when it was 1. The two are never high together. ext_addr and ext_wdata hold the latched request values while the strobe is on.
- R7: core_rdata equals the ext_rdata value present at the edge that ends the last strobe cycle.
- R8: core_done is high for exactly one cycle per access.
- R9: ext_oe in each cycle equals the inverse of ext_suspend sampled at the previous rising edge.
- R10: The sequence does not advance at any edge where ext_suspend is high, nor at the edge that follows one where it was high. Such edges count neither as setup, nor as wait, nor as the completing edge.
- R11: core_req is ignored while an access is in progress, so no extra done follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | One-cycle access request, taken only when idle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Access address; the top bits select the bank |
| core_wdata | input | DW | Write data |
| core_rdata | output | DW | Read data captured on the last strobe cycle |
| core_done | output | 1 | One-cycle completion pulse |
| cfg_wait | input | NB*3 | Wait count per bank, 3 bits each, bank 0 lowest |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data |
| ext_bsel | output | NB | One-hot bank select |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_oe | output | 1 | Pad drive enable; 0 means the bus pins float |
| ext_ack | input | 1 | External acknowledge; low stretches the access |
| ext_suspend | input | 1 | Bus suspend request |

## Verification
The hardest case to reach from the ports is a suspend that falls on the cycle where the counted waits run out, while acknowledge is still low. In that case the freeze and the acknowledge stretch overlap, and each edge has to be attributed to the right cause. The bench covers it by sliding a suspend window of several lengths across every position of the access, alone and combined with a late acknowledge release. For every combination, the bench finds the expected completion edge by walking the edges one at a time against the rules above.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int unsigned WCNT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_ACKWAIT,
    ST_DONE
  } ewc_state_e;
endpackage

// File: rtl/ewc_bank_decode.sv
module ewc_bank_decode #(
  parameter int unsigned NB = 4,
  parameter int unsigned WW = 3,
  localparam int unsigned BB = $clog2(NB)
) (
  input  logic [BB-1:0]    bank_idx,
  input  logic [NB*WW-1:0] cfg,
  output logic [NB-1:0]    sel_onehot,
  output logic [WW-1:0]    wait_cnt
);
  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign sel_onehot[b] = (bank_idx == BB'(b));
  end

  assign wait_cnt = cfg[int'(bank_idx)*WW +: WW];
endmodule

// File: rtl/ewc_wait_count.sv
module ewc_wait_count #(
  parameter int unsigned WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R3: the sequencer never counts below zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
  import ewc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic stall,
  input  logic ack,
  input  logic cnt_zero,
  output logic accept,
  output logic cnt_load,
  output logic cnt_dec,
  output logic capture,
  output logic addr_phase,
  output logic strobe,
  output logic done
);
  ewc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept  = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP: if (!stall) begin
        cnt_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: if (!stall) begin
        if (!cnt_zero) cnt_dec = 1'b1;
        else if (ack) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end else state_d = ST_ACKWAIT;
      end
      ST_ACKWAIT: if (!stall && ack) begin
        capture = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign strobe     = (state_q == ST_WAIT) || (state_q == ST_ACKWAIT);
  assign addr_phase = strobe || (state_q == ST_SETUP);
  assign done       = (state_q == ST_DONE);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && addr_phase) |=> $stable(state_q));
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACKWAIT) && !ack) |=> (state_q == ST_ACKWAIT));
endmodule

// File: rtl/xbus_waitstate_ctl.sv
module xbus_waitstate_ctl #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned NB = 4,
  localparam int unsigned WW = ewc_pkg::WCNT_W,
  localparam int unsigned BB = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_req,
  input  logic             core_we,
  input  logic [AW-1:0]    core_addr,
  input  logic [DW-1:0]    core_wdata,
  output logic [DW-1:0]    core_rdata,
  output logic             core_done,
  input  logic [NB*WW-1:0] cfg_wait,
  output logic [AW-1:0]    ext_addr,
  output logic [DW-1:0]    ext_wdata,
  input  logic [DW-1:0]    ext_rdata,
  output logic [NB-1:0]    ext_bsel,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic             ext_oe,
  input  logic             ext_ack,
  input  logic             ext_suspend
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          we_q, oe_q, stall;
  logic          accept, cnt_load, cnt_dec, capture, addr_phase, strobe, done;
  logic          cnt_zero;
  logic [NB-1:0] sel_onehot;
  logic [WW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= core_addr;
      wdata_q <= core_wdata;
      we_q    <= core_we;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (capture) rdata_q <= ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) oe_q <= 1'b1;
    else             oe_q <= ~ext_suspend;
  end

  assign stall = ext_suspend | ~oe_q;

  ewc_bank_decode #(.NB(NB), .WW(WW)) i_dec (
    .bank_idx   (addr_q[AW-1 -: BB]),
    .cfg        (cfg_wait),
    .sel_onehot (sel_onehot),
    .wait_cnt   (wait_cnt)
  );

  ewc_wait_count #(.WW(WW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (wait_cnt),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  ewc_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (core_req),
    .stall      (stall),
    .ack        (ext_ack),
    .cnt_zero   (cnt_zero),
    .accept     (accept),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec),
    .capture    (capture),
    .addr_phase (addr_phase),
    .strobe     (strobe),
    .done       (done)
  );

  assign ext_addr   = addr_q;
  assign ext_wdata  = wdata_q;
  assign ext_bsel   = addr_phase ? sel_onehot : '0;
  assign ext_rd     = strobe & ~we_q;
  assign ext_wr     = strobe & we_q;
  assign ext_oe     = oe_q;
  assign core_done  = done;
  assign core_rdata = rdata_q;

  p_bsel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ext_bsel));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ext_rd && ext_wr));
  p_suspend_float_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_suspend |=> !ext_oe);
  p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_done |-> $past(ext_rd || ext_wr));
endmodule

// File: tb/test_xbus_waitstate_ctl.sv
module test_xbus_waitstate_ctl;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, core_rdata;
  logic core_done;
  logic [NB*3-1:0] cfg_wait = '0;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata, ext_rdata = '0;
  logic [NB-1:0] ext_bsel;
  logic ext_rd, ext_wr, ext_oe;
  logic ext_ack = 1'b1, ext_suspend = 1'b0;

  int nchk = 0, nerr = 0, run_idx = 0;

  always #2 clk = ~clk;

  xbus_waitstate_ctl #(.AW(AW), .DW(DW), .NB(NB)) i_xbus_waitstate_ctl (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_done(core_done), .cfg_wait(cfg_wait), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_bsel(ext_bsel),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_oe(ext_oe), .ext_ack(ext_ack),
    .ext_suspend(ext_suspend));

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit sb(int j, int s1, int s2);
    return (j >= s1) && (j <= s2);
  endfunction

  // One access; ack high at edge j when j > ack_r; suspend high at edges s1..s2.
  task automatic run_access(input int bank, input bit we, input int n, input int ack_r,
                            input int s1, input int s2, input bit midreq, input string tag);
    int exp_l, adv, got;
    bit ok_stb, ok_sel, ok_oe, ok_dat;
    logic [DW-1:0] base, wd;
    logic [AW-1:0] ad;
    run_idx++;
    base = DW'(run_idx) << 8;
    wd = 32'hA5000000 ^ DW'(run_idx);
    ad = {bank[1:0], 30'(run_idx * 4 + 3)};
    for (int b = 0; b < NB; b++)
      cfg_wait[b*3 +: 3] = (b == bank) ? 3'(n) : 3'(n + 3);
    // expected completion edge, walking the rules R3 R4 R5 R10
    exp_l = -1; adv = 0;
    for (int j = 1; j < 300 && exp_l < 0; j++) begin
      if (!(sb(j, s1, s2) || sb(j - 1, s1, s2))) begin
        if (adv < n + 1) adv++;
        else if (j > ack_r) exp_l = j;
      end
    end
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = ad; core_wdata = wd;
    ext_ack = (ack_r < 0); ext_suspend = 1'b0; ext_rdata = base;
    @(posedge clk);
    got = -1; ok_stb = 1; ok_sel = 1; ok_oe = 1; ok_dat = 1;
    for (int j = 1; j < 300 && got < 0; j++) begin
      @(negedge clk);
      core_req = midreq && (j == 2);
      if (core_done) got = j - 1;
      else begin
        if (ext_oe != !sb(j - 1, s1, s2)) ok_oe = 0;
        if (ext_rd || ext_wr) begin
          if (ext_rd != !we || ext_wr != we) ok_stb = 0;
          if (ext_bsel != NB'(1 << bank)) ok_sel = 0;
          if (ext_addr != ad || (we && ext_wdata != wd)) ok_dat = 0;
        end
        ext_ack = (j > ack_r);
        ext_suspend = sb(j, s1, s2);
        ext_rdata = base + DW'(j);
        @(posedge clk);
      end
    end
    ext_suspend = 1'b0; ext_ack = 1'b1; core_req = 1'b0;
    chk(got == exp_l, {tag, " completion latency"}, got, exp_l);
    chk(ok_stb, "R6 strobe direction", ok_stb, 1);
    chk(ok_sel, "R2 bank select during access", ok_sel, 1);
    chk(ok_dat, "R6 address/write data held", ok_dat, 1);
    chk(ok_oe, "R9 drive enable follows suspend", ok_oe, 1);
    if (!we) chk(core_rdata == base + DW'(exp_l), "R7 read data capture", core_rdata, base + DW'(exp_l));
    @(negedge clk);
    chk(core_done == 1'b0, "R8 done single cycle", core_done, 0);
    chk(ext_bsel == '0, "R2 select idle", ext_bsel, 0);
    if (midreq) begin
      got = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (core_done || ext_rd || ext_wr) got = 1;
      end
      chk(got == 0, "R11 request while busy ignored", got, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(core_done == 0, "R1 done at reset", core_done, 0);
    chk(ext_rd == 0 && ext_wr == 0, "R1 strobes at reset", {ext_rd, ext_wr}, 0);
    chk(ext_bsel == '0, "R1 selects at reset", ext_bsel, 0);
    chk(ext_oe == 1, "R1 drive enable at reset", ext_oe, 1);
    // R3 R2 R6 R7: every bank, every wait count, both directions
    for (int b = 0; b < NB; b++)
      for (int n = 0; n < 8; n++)
        for (int w = 0; w < 2; w++)
          run_access(b, w[0], n, 0, 99, 0, 1'b0, "R3");
    // R4 R5 R11: acknowledge released at many points
    for (int n = 0; n < 6; n += 2)
      for (int r = 0; r < 12; r++)
        run_access(1, 1'b0, n, r, 99, 0, 1'b1, (r > n + 1) ? "R4" : "R5");
    // R10 R9: suspend windows over every position, also with late acknowledge
    for (int n = 1; n < 4; n += 2)
      for (int s = 1; s < 8; s++)
        for (int len = 0; len < 3; len++) begin
          run_access(2, 1'b0, n, 0, s, s + len, 1'b0, "R10");
          run_access(3, 1'b1, n, n + 3, s, s + len, 1'b0, "R10");
        end
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule